// File: doc/BRIEF.md
# Field Error Interrupt Generator

This block turns the error flags of each outgoing video packet into an active-low interrupt level. Every flag is qualified by a sensitivity mask, the same 15-bit enable vector that governs the errored-field counter, so the interrupt reacts only to the error kinds that software has chosen. The output is re-evaluated when a packet-exit strobe marks the departure of a packet. It then holds steady until the next packet has passed.

In level mode, each packet exit replaces the interrupt state with the result for that packet. In sticky mode, the block records every enabled error in a per-flag pending register. The interrupt stays asserted until the host has read each flag that raised it. A host read is presented as a one-cycle strobe with a binary flag index. It clears only the pending bit at that index. The open-drain pad and its pull-up sit outside this block.

Top module: `fld_irq_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, irq_n is high and no flag is pending.
- R2: A packet-exit strobe in a cycle where any flag bit i has both flag_vec[i] and sens_mask[i] high drives irq_n low from the next cycle, in either mode.
- R3: A flag bit whose sens_mask bit is low never causes irq_n to go low, whatever its flag_vec value.
- R4: In level mode (sticky_en low), a packet-exit strobe with no enabled flag set drives irq_n high from the next cycle.
- R5: In level mode, irq_n changes only in the cycle after a packet-exit strobe; changes on flag_vec or sens_mask between strobes have no effect on it.
- R6: In sticky mode (sticky_en high), enabled flags accumulate into the pending set at each packet exit, and irq_n stays low across later packets without errors until reads clear the pending set.
- R7: In sticky mode, a host read strobe with index k (binary, bit k of flag_vec) clears only pending bit k; irq_n goes high in the cycle after the last pending bit is cleared.
- R8: If a packet exit sets pending bit k in the same cycle as a host read of index k, the set wins: bit k stays pending and irq_n stays low.
- R9: Host reads have no effect in level mode, and reads with an index of 15 or more never clear any pending bit.
- R10: While sticky_en is low the pending set is emptied, and irq_n holds its value until the next packet exit; after sticky_en returns high, earlier errors are not pending again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_vec | input | 15 | Error flags of the outgoing packet, one bit per flag |
| sens_mask | input | 15 | Sensitivity mask; bit i enables flag i |
| pkt_exit | input | 1 | One-cycle strobe: the outgoing packet has left |
| sticky_en | input | 1 | High selects sticky mode, low selects level mode |
| host_rd | input | 1 | One-cycle strobe: the host reads one flag |
| host_rd_idx | input | 4 | Binary index of the flag being read |
| irq_n | output | 1 | Interrupt level, low when asserted |

## Verification
A packet exit can set a pending bit in the same cycle that a host read clears one. The bench provokes this in two ways: it reads the very flag that the exiting packet raises, and it reads a different flag while a new one is raised. The first case must keep irq_n low, by the rule that the set wins. In the second case the read bit is dropped and the new bit stays. A later read of each remaining index shows this by when irq_n returns high.

// File: rtl/fld_irq_pkg.sv
// Package fld_irq_pkg
// Shared types for the field error interrupt generator.
// Assumes: nothing beyond IEEE 1800-2017.
package fld_irq_pkg;

    // Interrupt operating mode.
    typedef enum logic {
        IRQ_LEVEL  = 1'b0,
        IRQ_STICKY = 1'b1
    } irq_mode_e;

    // Map the sticky enable pin to a mode.
    function automatic irq_mode_e mode_of(input logic sticky);
        return sticky ? IRQ_STICKY : IRQ_LEVEL;
    endfunction

endpackage

// File: rtl/fld_irq_qual.sv
// Module fld_irq_qual
// Qualifies the outgoing flags with the sensitivity mask.
// It gives a per-flag hit vector and an any-hit summary.
// Assumes: flag_vec and sens_mask are valid in the packet-exit cycle.
module fld_irq_qual #(
    parameter int unsigned NUM_FLAGS = 15
) (
    input  logic [NUM_FLAGS-1:0] flag_vec,
    input  logic [NUM_FLAGS-1:0] sens_mask,
    output logic [NUM_FLAGS-1:0] hit_vec,
    output logic                 hit_any
);

    // Mask each flag and reduce to a summary.
    always_comb begin
        hit_vec = flag_vec & sens_mask;
        hit_any = |hit_vec;
    end

endmodule

// File: rtl/fld_irq_pend.sv
// Module fld_irq_pend
// Per-flag pending register for sticky mode. Each bit is set by an
// enabled hit at packet exit. A host read of its index clears it, and a
// set beats a clear in the same cycle. The register is emptied while
// level mode is selected.
// Assumes: the read index is binary; indices with no flag match no bit.
module fld_irq_pend #(
    parameter int unsigned NUM_FLAGS = 15,
    parameter int unsigned IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  fld_irq_pkg::irq_mode_e mode,
    input  logic                 pkt_exit,
    input  logic [NUM_FLAGS-1:0] hit_vec,
    input  logic                 host_rd,
    input  logic [IDX_W-1:0]     host_rd_idx,
    output logic [NUM_FLAGS-1:0] pend_q,
    output logic                 pend_next_any
);
    import fld_irq_pkg::*;

    logic [NUM_FLAGS-1:0] pend_d;

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_cell
        logic set_b;
        logic clr_b;

        // Decode set and clear requests for this flag.
        always_comb begin
            set_b = pkt_exit && hit_vec[gi];
            clr_b = host_rd && (host_rd_idx == IDX_W'(gi));
        end

        // Next state: empty in level mode, set over clear in sticky mode.
        always_comb begin
            if (mode != IRQ_STICKY) begin
                pend_d[gi] = 1'b0;
            end else begin
                pend_d[gi] = set_b | (pend_q[gi] & ~clr_b);
            end
        end

        // Pending flop for this flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[gi] <= 1'b0;
            end else begin
                pend_q[gi] <= pend_d[gi];
            end
        end
    end

    // Summary of the next pending state, used by the output stage.
    always_comb pend_next_any = |pend_d;

endmodule

// File: rtl/fld_irq_drv.sv
// Module fld_irq_drv
// Output register for the interrupt level. In level mode it loads the
// hit summary at each packet exit and holds otherwise. In sticky mode it
// follows the next pending state.
// Assumes: pend_next_any is the next-cycle content of the pending set.
module fld_irq_drv (
    input  logic                   clk,
    input  logic                   rst_n,
    input  fld_irq_pkg::irq_mode_e mode,
    input  logic                   pkt_exit,
    input  logic                   hit_any,
    input  logic                   pend_next_any,
    output logic                   irq_n
);
    import fld_irq_pkg::*;

    // Register the active-low interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (mode == IRQ_STICKY) begin
            irq_n <= ~pend_next_any;
        end else if (pkt_exit) begin
            irq_n <= ~hit_any;
        end
    end

endmodule

// File: rtl/fld_irq_gen.sv
// Module fld_irq_gen (top)
// Field error interrupt generator. It masks the outgoing flags, keeps
// the sticky pending set and registers the active-low interrupt level.
// Assumes: pkt_exit and host_rd are one-cycle strobes; synchronous
// active-low reset.
module fld_irq_gen #(
    parameter int unsigned NUM_FLAGS = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FLAGS-1:0]         flag_vec,
    input  logic [NUM_FLAGS-1:0]         sens_mask,
    input  logic                         pkt_exit,
    input  logic                         sticky_en,
    input  logic                         host_rd,
    input  logic [$clog2(NUM_FLAGS)-1:0] host_rd_idx,
    output logic                         irq_n
);
    import fld_irq_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_FLAGS);

    irq_mode_e            mode;
    logic [NUM_FLAGS-1:0] hit_vec;
    logic                 hit_any;
    logic [NUM_FLAGS-1:0] pend_q;
    logic                 pend_next_any;

    // Decode the operating mode.
    always_comb mode = mode_of(sticky_en);

    fld_irq_qual #(
        .NUM_FLAGS(NUM_FLAGS)
    ) u_qual (
        .flag_vec (flag_vec),
        .sens_mask(sens_mask),
        .hit_vec  (hit_vec),
        .hit_any  (hit_any)
    );

    fld_irq_pend #(
        .NUM_FLAGS(NUM_FLAGS),
        .IDX_W    (IDX_W)
    ) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .pkt_exit     (pkt_exit),
        .hit_vec      (hit_vec),
        .host_rd      (host_rd),
        .host_rd_idx  (host_rd_idx),
        .pend_q       (pend_q),
        .pend_next_any(pend_next_any)
    );

    fld_irq_drv u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .pkt_exit     (pkt_exit),
        .hit_any      (hit_any),
        .pend_next_any(pend_next_any),
        .irq_n        (irq_n)
    );

endmodule

// File: rtl/fld_irq_chk.sv
// Module fld_irq_chk
// Assertion checker for fld_irq_gen, attached through bind.
// Assumes: sampled on the rising clock edge, reset synchronous active low.
module fld_irq_chk #(
    parameter int unsigned NUM_FLAGS = 15,
    parameter int unsigned IDX_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] flag_vec,
    input logic [NUM_FLAGS-1:0] sens_mask,
    input logic                 pkt_exit,
    input logic                 sticky_en,
    input logic                 host_rd,
    input logic [IDX_W-1:0]     host_rd_idx,
    input logic [NUM_FLAGS-1:0] pend_q,
    input logic                 irq_n
);

    logic [NUM_FLAGS-1:0] chk_hits;
    logic [NUM_FLAGS-1:0] rd_onehot;

    // Independent one-hot decode of the read index and masked hits.
    always_comb begin
        chk_hits  = flag_vec & sens_mask;
        rd_onehot = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (host_rd && (host_rd_idx == IDX_W'(i))) rd_onehot[i] = 1'b1;
        end
    end

    a_r1_reset_high: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    a_r2_assert_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_exit && (chk_hits != '0)) |=> !irq_n);

    a_r4_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_en && pkt_exit && (chk_hits == '0)) |=> irq_n);

    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_en && !pkt_exit) |=> $stable(irq_n));

    a_r6_sticky_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && !irq_n && !host_rd) |=> !irq_n);

    a_r7_last_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && host_rd && (pend_q == rd_onehot) && (pend_q != '0)
         && !(pkt_exit && (chk_hits != '0))) |=> irq_n);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && pkt_exit && ((chk_hits & rd_onehot) != '0)) |=> !irq_n);

endmodule

bind fld_irq_gen fld_irq_chk #(
    .NUM_FLAGS(NUM_FLAGS),
    .IDX_W    (IDX_W)
) u_fld_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_vec   (flag_vec),
    .sens_mask  (sens_mask),
    .pkt_exit   (pkt_exit),
    .sticky_en  (sticky_en),
    .host_rd    (host_rd),
    .host_rd_idx(host_rd_idx),
    .pend_q     (pend_q),
    .irq_n      (irq_n)
);

// File: tb/test_fld_irq_gen.sv
// Scoreboard bench for fld_irq_gen: a driver task applies one cycle of
// stimulus, steps a reference model and queues the expected irq_n; a
// monitor pops and compares at each falling edge.
module test_fld_irq_gen;

    localparam int unsigned NF = 15;
    localparam int unsigned IW = $clog2(NF);

    typedef struct {
        logic  exp_irq_n;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] flag_vec = '0;
    logic [NF-1:0] sens_mask = '0;
    logic          pkt_exit = 1'b0;
    logic          sticky_en = 1'b0;
    logic          host_rd = 1'b0;
    logic [IW-1:0] host_rd_idx = '0;
    logic          irq_n;

    exp_t          sb_q[$];
    int            n_run  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    logic [NF-1:0] m_pend = '0;
    logic          m_irq_n = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    fld_irq_gen #(.NUM_FLAGS(NF)) i_fld_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_vec   (flag_vec),
        .sens_mask  (sens_mask),
        .pkt_exit   (pkt_exit),
        .sticky_en  (sticky_en),
        .host_rd    (host_rd),
        .host_rd_idx(host_rd_idx),
        .irq_n      (irq_n)
    );

    // Monitor: compare the queued expectation with the output.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (irq_n !== e.exp_irq_n) begin
                n_fail++;
                $display("FAIL %s: irq_n=%b expected %b", e.tag, irq_n, e.exp_irq_n);
            end
        end
    end

    // Driver: one cycle of stimulus, model step, expectation pushed after the edge.
    task automatic step(input logic [NF-1:0] f, input logic [NF-1:0] m,
                        input logic ex, input logic st, input logic rd,
                        input int idx, input string tag);
        logic [NF-1:0] hits;
        logic [NF-1:0] clr;
        exp_t          e;
        flag_vec    = f;
        sens_mask   = m;
        pkt_exit    = ex;
        sticky_en   = st;
        host_rd     = rd;
        host_rd_idx = IW'(idx);
        hits = f & m;
        clr  = (rd && idx < int'(NF)) ? (NF'(1) << idx) : '0;
        if (st) begin
            m_pend  = (m_pend & ~clr) | (ex ? hits : '0);
            m_irq_n = (m_pend == '0);
        end else begin
            m_pend = '0;
            if (ex) m_irq_n = (hits == '0);
        end
        @(posedge clk);
        #1;
        e.exp_irq_n = m_irq_n;
        e.tag       = tag;
        sb_q.push_back(e);
        pkt_exit = 1'b0;
        host_rd  = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(flag_vec, sens_mask, 1'b0, sticky_en, 1'b0, 0, tag);
    endtask

    localparam logic [NF-1:0] ALL = '1;

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        begin
            exp_t e;
            e.exp_irq_n = 1'b1; e.tag = "R1 in reset";
            sb_q.push_back(e);
        end
        rst_n = 1'b1;
        step('0, '0, 0, 0, 0, 0, "R1 after reset");

        // R2: level mode, enabled flag 3
        step(NF'(1) << 3, ALL, 1, 0, 0, 0, "R2 enabled hit");
        // R5: flags change without strobe
        step('0, '0, 0, 0, 0, 0, "R5 hold low");
        step(ALL, ALL, 0, 0, 0, 0, "R5 hold low 2");
        // R3: only masked-off flags
        step(15'h00F0, 15'h7F0F, 1, 0, 0, 0, "R3 masked flags");
        step(ALL, '0, 1, 0, 0, 0, "R3 mask zero");
        step(ALL, ALL, 0, 0, 0, 0, "R5 hold high");
        // R2 bit 14 boundary, then R4 clean release
        step(NF'(1) << 14, NF'(1) << 14, 1, 0, 0, 0, "R2 top flag");
        // R9: host read in level mode ignored
        step('0, ALL, 0, 0, 1, 14, "R9 read in level mode");
        step('0, ALL, 1, 0, 0, 0, "R4 clean exit");

        // R6: sticky accumulation
        step(15'h0204, ALL, 1, 1, 0, 0, "R6 set bits 2,9");
        step('0, ALL, 1, 1, 0, 0, "R6 clean packet");
        step('0, ALL, 1, 1, 0, 0, "R6 clean packet 2");
        // R9: out-of-range index
        step('0, ALL, 0, 1, 1, 15, "R9 index 15");
        // R7: reads
        step('0, ALL, 0, 1, 1, 2, "R7 read 2 keeps 9");
        step('0, ALL, 0, 1, 1, 9, "R7 read 9 releases");
        idle(2, "R7 stays high");

        // R8: set and clear of bit 5 together
        step(NF'(1) << 5, ALL, 1, 1, 1, 5, "R8 set beats clear");
        step('0, ALL, 0, 1, 1, 5, "R8 later read releases");
        // R8: read 0 while bit 7 is raised
        step(NF'(1) << 0, ALL, 1, 1, 0, 0, "R6 set bit 0");
        step(NF'(1) << 7, ALL, 1, 1, 1, 0, "R8 read 0 with new 7");
        step('0, ALL, 0, 1, 1, 0, "R8 bit 0 gone, 7 holds");
        step('0, ALL, 0, 1, 1, 7, "R7 read 7 releases");
        // R3 in sticky mode
        step(ALL, '0, 1, 1, 0, 0, "R3 sticky masked");

        // R10: leave sticky mode with a pending bit
        step(NF'(1) << 11, ALL, 1, 1, 0, 0, "R6 set bit 11");
        step('0, ALL, 0, 0, 0, 0, "R10 held on mode change");
        step('0, ALL, 0, 0, 1, 11, "R10 held, read ignored");
        step('0, ALL, 1, 0, 0, 0, "R10 clean exit releases");
        step('0, ALL, 1, 1, 0, 0, "R10 pending was dropped");
        step('0, ALL, 0, 1, 1, 11, "R10 stays high");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule